// File: doc/BRIEF.md
# Bus Access Permission and Abort Unit

This unit sits between a processor bus master and the chip-select decoder. For every access the master presents, it looks at the direction, the address, the one-hot chip-select from the decoder and a flag saying whether a real peripheral is mapped there. From these it decides three things. It decides whether the chip-select may pass. It decides whether the access must be aborted. It decides whether the access must be shown on the external bus.

A small control register, reached through a byte-wide configuration port, sets the policy. One chip-select can be locked to reads only and another to writes only. When a locked chip-select is used in the wrong direction, its chip-select is removed. Abort generation can be switched off, and then every access completes. A visibility control chooses between two behaviours: every access is mirrored onto the external bus, or only accesses aimed at external address space appear there. All three results are registered and appear one clock after the address phase.

Top module: `bus_guard`

## Requirements
- R1: After synchronous reset, `cs_out`, `abort` and `ext_en` are 0 and both configuration bytes read back as 0.
- R2: Configuration byte 0 (`cfg_sel`=0) holds abort-off in bit 0, external-only in bit 1 and the write-only lock in bit 2. Byte 1 (`cfg_sel`=1) holds the read-only lock in bit 0, which is control bit 8. Unused bits read 0. `cfg_rdata` shows the selected byte one cycle after `cfg_sel` is presented.
- R3: With the read-only lock set, a write on chip-select index `RO_IDX` (default 4) leaves that chip-select deasserted, while reads on it pass.
- R4: With the write-only lock set, a read on chip-select index `WO_IDX` (default 3) leaves that chip-select deasserted, while writes on it pass.
- R5: A direction violation from R3 or R4 raises `abort` unless abort-off is 1.
- R6: With abort-off 0, an access whose `acc_periph_ok` is 0 raises `abort`. With abort-off 1, no access ever raises `abort`.
- R7: With external-only 0 (reset value), `ext_en` is 1 for every access. With external-only 1, `ext_en` is 1 only when `acc_addr` >= `EXT_BASE` (default 0x8000_0000).
- R8: Results appear on the clock edge that ends the address phase. In a cycle with no valid access, all outputs return to 0, so each aborting access gives a one-cycle `abort` pulse.
- R9: A configuration write on the same edge as an access does not affect that access; it applies from the next access on.
- R10: Chip-selects other than the two lockable ones pass unchanged in both directions, whatever the locks are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | Configuration byte select (0 = bits 7..0, 1 = bits 15..8) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered configuration read data |
| acc_valid | input | 1 | Address phase valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address |
| acc_cs | input | NUM_CS | One-hot decoded chip-select |
| acc_periph_ok | input | 1 | A valid peripheral is mapped at the address |
| cs_out | output | NUM_CS | Gated chip-select, registered |
| abort | output | 1 | Abort pulse, registered |
| ext_en | output | 1 | External bus enable, registered |

## Verification
An exhaustive sweep crosses direction, both lock bits, the valid-peripheral flag and abort-off. It does this on the read-only chip-select, the write-only chip-select and an unrestricted one. The sweep separates a lock that gates the wrong direction from one that gates the wrong chip-select, and it separates a violation abort from an unmapped abort. Address patterns at, just below and far below the external boundary, under both visibility settings, expose an off-by-one or an inverted visibility control. Back-to-back aborting accesses followed by an idle cycle show whether the abort is a true pulse. A configuration write issued together with an access shows whether the new policy leaks into that same access.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // Field positions inside configuration byte 0
  localparam int LO_ABORT_OFF = 0;
  localparam int LO_EXT_ONLY  = 1;
  localparam int LO_WO_LOCK   = 2;
  localparam int LO_USED      = 3;
  // Field positions inside configuration byte 1 (control bit 8 upward)
  localparam int HI_RO_LOCK   = 0;
  localparam int HI_USED      = 1;

  typedef struct packed {
    logic ro_lock;
    logic wo_lock;
    logic ext_only;
    logic abort_off;
  } guard_cfg_t;
endpackage

// File: rtl/guard_cfg_regs.sv
module guard_cfg_regs
  import guard_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  output guard_cfg_t        cfg
);
  logic [BYTE_W-1:0] lo_view;
  logic [BYTE_W-1:0] hi_view;

  always_comb begin
    lo_view               = '0;
    lo_view[LO_ABORT_OFF] = cfg.abort_off;
    lo_view[LO_EXT_ONLY]  = cfg.ext_only;
    lo_view[LO_WO_LOCK]   = cfg.wo_lock;
    hi_view               = '0;
    hi_view[HI_RO_LOCK]   = cfg.ro_lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we) begin
        if (!cfg_sel) begin
          cfg.abort_off <= cfg_wdata[LO_ABORT_OFF];
          cfg.ext_only  <= cfg_wdata[LO_EXT_ONLY];
          cfg.wo_lock   <= cfg_wdata[LO_WO_LOCK];
        end else begin
          cfg.ro_lock   <= cfg_wdata[HI_RO_LOCK];
        end
      end
      cfg_rdata <= cfg_sel ? hi_view : lo_view;
    end
  end

  // Unused bits of the upper byte must read back as zero
  assert_hi_unused_zero_R2 : assert property (@(posedge clk) disable iff (rst)
    cfg_sel |=> cfg_rdata[BYTE_W-1:HI_USED] == '0);

  // Unused bits of the lower byte must read back as zero
  assert_lo_unused_zero_R2 : assert property (@(posedge clk) disable iff (rst)
    !cfg_sel |=> cfg_rdata[BYTE_W-1:LO_USED] == '0);
endmodule

// File: rtl/guard_rules.sv
module guard_rules
  import guard_pkg::*;
#(
  parameter int                NUM_CS   = 8,
  parameter int                ADDR_W   = 32,
  parameter int                RO_IDX   = 4,
  parameter int                WO_IDX   = 3,
  parameter logic [ADDR_W-1:0] EXT_BASE = {1'b1, {(ADDR_W-1){1'b0}}}
) (
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NUM_CS-1:0] acc_cs,
  input  logic              acc_periph_ok,
  input  guard_cfg_t        cfg,
  output logic [NUM_CS-1:0] cs_pass,
  output logic              abort_req,
  output logic              ext_req
);
  logic [NUM_CS-1:0] deny;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_lane
    if (i == RO_IDX) begin : g_ro
      assign deny[i] = acc_cs[i] & cfg.ro_lock & acc_write;
    end else if (i == WO_IDX) begin : g_wo
      assign deny[i] = acc_cs[i] & cfg.wo_lock & ~acc_write;
    end else begin : g_free
      assign deny[i] = 1'b0;
    end
  end

  always_comb begin
    cs_pass   = acc_cs & ~deny;
    abort_req = ~cfg.abort_off & ((|deny) | ~acc_periph_ok);
    ext_req   = ~cfg.ext_only | (acc_addr >= EXT_BASE);
  end
endmodule

// File: rtl/guard_out_reg.sv
module guard_out_reg #(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [NUM_CS-1:0] cs_pass,
  input  logic              abort_req,
  input  logic              ext_req,
  output logic [NUM_CS-1:0] cs_out,
  output logic              abort,
  output logic              ext_en
);
  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      cs_out <= '0;
      abort  <= 1'b0;
      ext_en <= 1'b0;
    end else begin
      cs_out <= cs_pass;
      abort  <= abort_req;
      ext_en <= ext_req;
    end
  end
endmodule

// File: rtl/bus_guard.sv
module bus_guard
  import guard_pkg::*;
#(
  parameter int                NUM_CS   = 8,
  parameter int                ADDR_W   = 32,
  parameter int                BYTE_W   = 8,
  parameter int                RO_IDX   = 4,
  parameter int                WO_IDX   = 3,
  parameter logic [ADDR_W-1:0] EXT_BASE = {1'b1, {(ADDR_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NUM_CS-1:0] acc_cs,
  input  logic              acc_periph_ok,
  output logic [NUM_CS-1:0] cs_out,
  output logic              abort,
  output logic              ext_en
);
  guard_cfg_t        cfg;
  logic [NUM_CS-1:0] cs_pass;
  logic              abort_req;
  logic              ext_req;

  guard_cfg_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg(cfg)
  );

  guard_rules #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .RO_IDX(RO_IDX), .WO_IDX(WO_IDX),
    .EXT_BASE(EXT_BASE)
  ) u_rules (
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_cs(acc_cs),
    .acc_periph_ok(acc_periph_ok), .cfg(cfg), .cs_pass(cs_pass),
    .abort_req(abort_req), .ext_req(ext_req)
  );

  guard_out_reg #(.NUM_CS(NUM_CS)) u_out (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .cs_pass(cs_pass),
    .abort_req(abort_req), .ext_req(ext_req), .cs_out(cs_out),
    .abort(abort), .ext_en(ext_en)
  );

  assert_ro_write_gated_R3 : assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && acc_cs[RO_IDX] && cfg.ro_lock |=> !cs_out[RO_IDX]);

  assert_wo_read_gated_R4 : assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_write && acc_cs[WO_IDX] && cfg.wo_lock |=> !cs_out[WO_IDX]);

  assert_violation_aborts_R5 : assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && acc_cs[RO_IDX] && cfg.ro_lock && !cfg.abort_off
    |=> abort);

  assert_unmapped_aborts_R6 : assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_periph_ok && !cfg.abort_off |=> abort);

  assert_abort_off_silent_R6 : assert property (@(posedge clk) disable iff (rst)
    acc_valid && cfg.abort_off |=> !abort);

  assert_mirror_all_R7 : assert property (@(posedge clk) disable iff (rst)
    acc_valid && !cfg.ext_only |=> ext_en);

  assert_idle_clear_R8 : assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !abort && !ext_en && cs_out == '0);

  assert_free_cs_pass_R10 : assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_cs != '0 && !acc_cs[RO_IDX] && !acc_cs[WO_IDX]
    |=> cs_out == $past(acc_cs));
endmodule

// File: tb/test_bus_guard.sv
`timescale 1ns/1ps
module test_bus_guard;
  localparam int          NUM_CS = 8;
  localparam int          ADDR_W = 32;
  localparam logic [31:0] EXT    = 32'h8000_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;
  logic              acc_valid = 1'b0;
  logic              acc_write = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [NUM_CS-1:0] acc_cs = '0;
  logic              acc_periph_ok = 1'b0;
  logic [NUM_CS-1:0] cs_out;
  logic              abort;
  logic              ext_en;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  // shadow of the policy, written only by the bench
  bit  s_aoff = 0, s_ext = 0, s_wo = 0, s_ro = 0;

  always #10 clk = ~clk;

  bus_guard i_bus_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_cs(acc_cs),
    .acc_periph_ok(acc_periph_ok), .cs_out(cs_out), .abort(abort),
    .ext_en(ext_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!sel) begin s_aoff = d[0]; s_ext = d[1]; s_wo = d[2]; end
    else s_ro = d[0];
  endtask

  task automatic cfg_read(input bit sel, output logic [7:0] d);
    @(negedge clk);
    cfg_sel = sel;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic set_policy(input bit aoff, input bit ext, input bit wo, input bit ro);
    cfg_write(1'b0, {5'b0, wo, ext, aoff});
    cfg_write(1'b1, {7'b0, ro});
  endtask

  // one access; results sampled at the negedge after the capturing edge
  task automatic access(input bit w, input int idx, input bit ok, input logic [31:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_cs = NUM_CS'(1) << idx;
    acc_periph_ok = ok; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic bit deny_of(bit w, int idx);
    return (idx == 4 && s_ro && w) || (idx == 3 && s_wo && !w);
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 cs_out", 32'(cs_out), 0);
    chk("R1 abort", 32'(abort), 0);
    chk("R1 ext_en", 32'(ext_en), 0);
    cfg_read(1'b0, d); chk("R1 byte0", 32'(d), 0);
    cfg_read(1'b1, d); chk("R1 byte1", 32'(d), 0);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    cfg_write(1'b0, 8'hFF);
    cfg_write(1'b1, 8'hFF);
    cfg_read(1'b0, d); chk("R2 byte0 all ones", 32'(d), 32'h07);
    cfg_read(1'b1, d); chk("R2 byte1 all ones", 32'(d), 32'h01);
    cfg_write(1'b0, 8'h04);
    cfg_read(1'b0, d); chk("R2 byte0 wo only", 32'(d), 32'h04);
    cfg_read(1'b1, d); chk("R2 byte1 untouched", 32'(d), 32'h01);
    set_policy(0, 0, 0, 0);
  endtask

  task automatic t_sweep;
    int lanes [3] = '{3, 4, 6};
    for (int l = 0; l < 3; l++)
      for (int v = 0; v < 32; v++) begin
        bit w, ro, wo, ok, aoff, dn;
        logic [31:0] exp_cs;
        string tg;
        {w, ro, wo, ok, aoff} = 5'(v);
        set_policy(aoff, 1'b0, wo, ro);
        dn = deny_of(w, lanes[l]);
        exp_cs = dn ? 0 : (32'd1 << lanes[l]);
        access(w, lanes[l], ok, 32'h0000_1000);
        tg = (lanes[l] == 4) ? "R3" : (lanes[l] == 3) ? "R4" : "R10";
        chk({tg, " cs gating"}, 32'(cs_out), exp_cs);
        chk(dn ? "R5 violation abort" : "R6 unmapped abort",
            32'(abort), 32'(!aoff && (dn || !ok)));
        chk("R7 mirror all", 32'(ext_en), 1);
      end
    set_policy(0, 0, 0, 0);
  endtask

  task automatic t_visibility;
    set_policy(0, 0, 0, 0);
    access(1'b0, 1, 1'b1, 32'h0000_0040); chk("R7 internal mirrored", 32'(ext_en), 1);
    set_policy(0, 1, 0, 0);
    access(1'b0, 1, 1'b1, 32'h0000_0040); chk("R7 internal hidden", 32'(ext_en), 0);
    access(1'b1, 1, 1'b1, EXT - 1);       chk("R7 below boundary", 32'(ext_en), 0);
    access(1'b1, 1, 1'b1, EXT);           chk("R7 at boundary", 32'(ext_en), 1);
    access(1'b0, 1, 1'b1, 32'hFFFF_FFF0); chk("R7 high external", 32'(ext_en), 1);
    set_policy(0, 0, 0, 0);
  endtask

  task automatic t_pulse;
    set_policy(0, 0, 0, 1);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_cs = NUM_CS'(1) << 4;
    acc_periph_ok = 1'b1; acc_addr = 32'h10;
    @(negedge clk);
    chk("R8 first abort", 32'(abort), 1);
    acc_write = 1'b0; acc_cs = NUM_CS'(1) << 2; acc_periph_ok = 1'b0;
    @(negedge clk);
    chk("R8 second abort", 32'(abort), 1);
    chk("R8 second cs", 32'(cs_out), 32'h04);
    acc_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle abort low", 32'(abort), 0);
    chk("R8 idle cs low", 32'(cs_out), 0);
    chk("R8 idle ext low", 32'(ext_en), 0);
    set_policy(0, 0, 0, 0);
  endtask

  task automatic t_same_edge;
    set_policy(0, 0, 0, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h01;
    acc_valid = 1'b1; acc_write = 1'b1; acc_cs = NUM_CS'(1) << 4;
    acc_periph_ok = 1'b1; acc_addr = 32'h20;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0; s_ro = 1;
    chk("R9 old policy cs", 32'(cs_out), 32'h10);
    chk("R9 old policy abort", 32'(abort), 0);
    access(1'b1, 4, 1'b1, 32'h20);
    chk("R9 new policy cs", 32'(cs_out), 0);
    chk("R9 new policy abort", 32'(abort), 1);
    set_policy(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_readback;
    t_sweep;
    t_visibility;
    t_pulse;
    t_same_edge;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule